// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit core's load/store stage and a word-wide, byte-addressable data memory. For every request it adds a sign-extended 16-bit displacement to a base value to form a byte address. It issues the word address and a set of per-lane byte strobes. For stores it moves the source bytes onto the lanes selected by the low address bits. For loads it takes the addressed byte, half-word or word out of the returned memory word and widens it to 32 bits with sign or zero fill. Byte order is little-endian, so a multi-byte item's address is that of its lowest-numbered lane.

An access whose address is not a multiple of its size raises a fault. The fault suppresses every strobe and the write, and it returns zero as load data. All outputs are registered once. A request presented in one cycle appears at the outputs after the next rising clock edge. `mem_rdata` must carry the word at the request's word address in the cycle the request is presented.

The operation code `req_op` has four fields. Bit 3 selects store (1) or load (0). Bit 2 selects zero fill (1) or sign fill (0). Bits 1:0 give the size: 00 byte, 01 half-word, 10 word, 11 reserved.

Top module: `ls_align_unit`

## Requirements
- R1: The byte address is `base_val` plus `offset` sign-extended to 32 bits. `mem_waddr` equals bits 31:2 of that sum one cycle after the request. The next word after byte address i is therefore at i+4, which is word address +1.
- R2: A byte access with address bits [1:0] = k drives `mem_be` with only bit k set.
- R3: A half-word access at an even address drives `mem_be` = 0011 for bits [1:0] = 00 and 1100 for bits [1:0] = 10.
- R4: A word access at an address with bits [1:0] = 00 drives `mem_be` = 1111.
- R5: A half-word access at an odd address, a word access with address bits [1:0] ≠ 00, or a request with size code 11 sets `misalign`. In that case `mem_be` = 0, `mem_we` = 0 and `ld_data` = 0.
- R6: On a store, each strobed lane of `mem_wdata` carries the bytes of `st_data` starting from its least significant byte. The lowest strobed lane takes `st_data[7:0]`, the next takes `st_data[15:8]`, and so on.
- R7: A byte load returns the addressed byte, sign-extended when op bit 2 = 0 and zero-extended when it is 1.
- R8: A half-word load returns the addressed half-word, with the same sign or zero rule as R7.
- R9: An aligned word load returns `mem_rdata` unchanged.
- R10: With `req_en` low, `mem_be`, `mem_we`, `misalign` and `ld_data` are all zero whatever the other inputs are.
- R11: While `rst` is high at a clock edge, every output is cleared to zero.
- R12: `mem_we` is 1 only for an enabled, aligned store. A store returns `ld_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation: [3] store, [2] zero fill, [1:0] size |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_data | input | 32 | Store source register |
| mem_rdata | input | 32 | Memory word at the request's word address |
| mem_waddr | output | 30 | Word address to memory |
| mem_be | output | 4 | Byte-lane strobes, bit k = lane k |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 32 | Lane-placed store data |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Alignment fault |

## Verification
A wrong lane index shows up at the outputs one cycle after the request. The strobe sits on a neighbouring lane, the store bytes land in the wrong place, or the load returns a different byte of the word. An error in the displacement extension shows only for negative offsets, as a word address that is off by 0x4000 words. A wrong fill decision shows only when the selected byte or half-word has its top bit set. The vectors therefore sweep every lane, use data with the top bits set, and use offsets below zero, so each of these faults is visible in the first output cycle after the request.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic      is_store;
        logic      zero_fill;
        acc_size_e size;
    } acc_op_t;

    // true when the low address bits suit the access size
    function automatic logic size_aligned(acc_size_e sz, logic [1:0] lo);
        case (sz)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return (lo[0] == 1'b0);
            SZ_WORD: return (lo == 2'b00);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ls_ea_gen.sv
module ls_ea_gen #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] ea
);
    localparam int EXT_W = DATA_W - OFF_W;

    logic [DATA_W-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        ea      = base_val + off_ext;
    end
endmodule

// File: rtl/ls_lane_ctl.sv
module ls_lane_ctl
    import ls_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = $clog2(LANES)
) (
    input  logic              en,
    input  acc_op_t           op,
    input  logic [LIDX_W-1:0] lane,
    input  logic [DATA_W-1:0] st_data,
    output logic [LANES-1:0]  be,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              fault,
    output logic              ok
);
    logic [LANES-1:0] base_mask;

    always_comb begin
        case (op.size)
            SZ_BYTE: base_mask = LANES'(1);
            SZ_HALF: base_mask = LANES'(3);
            default: base_mask = '1;
        endcase
        ok    = en && size_aligned(op.size, 2'(lane));
        fault = en && !ok;
        be    = ok ? (base_mask << lane) : '0;
        we    = ok && op.is_store;
        wdata = (ok && op.is_store) ? (st_data << {lane, 3'b000}) : '0;
    end
endmodule

// File: rtl/ls_load_ext.sv
module ls_load_ext
    import ls_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LIDX_W = $clog2(DATA_W / 8)
) (
    input  logic              take,
    input  acc_op_t           op,
    input  logic [LIDX_W-1:0] lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] shifted;
    logic              fill;

    always_comb begin
        shifted = rdata >> {lane, 3'b000};
        fill    = 1'b0;
        result  = '0;
        if (take) begin
            case (op.size)
                SZ_BYTE: begin
                    fill   = shifted[7] && !op.zero_fill;
                    result = {{(DATA_W-8){fill}}, shifted[7:0]};
                end
                SZ_HALF: begin
                    fill   = shifted[15] && !op.zero_fill;
                    result = {{(DATA_W-16){fill}}, shifted[15:0]};
                end
                default: result = shifted;
            endcase
        end
    end
endmodule

// File: rtl/ls_align_unit.sv
module ls_align_unit
    import ls_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = $clog2(LANES),
    parameter int WA_W   = DATA_W - LIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_en,
    input  logic [3:0]        req_op,
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [WA_W-1:0]   mem_waddr,
    output logic [LANES-1:0]  mem_be,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] ld_data,
    output logic              misalign
);
    acc_op_t           op;
    logic [DATA_W-1:0] ea;
    logic [LANES-1:0]  be_n;
    logic              we_n, fault_n, ok_n;
    logic [DATA_W-1:0] wdata_n, ld_n;

    assign op = acc_op_t'(req_op);

    ls_ea_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_ea (
        .base_val (base_val),
        .offset   (offset),
        .ea       (ea)
    );

    ls_lane_ctl #(.DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)) u_lane (
        .en      (req_en),
        .op      (op),
        .lane    (ea[LIDX_W-1:0]),
        .st_data (st_data),
        .be      (be_n),
        .we      (we_n),
        .wdata   (wdata_n),
        .fault   (fault_n),
        .ok      (ok_n)
    );

    ls_load_ext #(.DATA_W(DATA_W), .LIDX_W(LIDX_W)) u_ld (
        .take   (ok_n && !op.is_store),
        .op     (op),
        .lane   (ea[LIDX_W-1:0]),
        .rdata  (mem_rdata),
        .result (ld_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_waddr <= '0;
            mem_be    <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            ld_data   <= '0;
            misalign  <= 1'b0;
        end else begin
            mem_waddr <= ea[DATA_W-1:LIDX_W];
            mem_be    <= be_n;
            mem_we    <= we_n;
            mem_wdata <= wdata_n;
            ld_data   <= ld_n;
            misalign  <= fault_n;
        end
    end
endmodule

// File: rtl/ls_align_chk.sv
module ls_align_chk #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = $clog2(LANES),
    parameter int WA_W   = DATA_W - LIDX_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_en,
    input logic [3:0]        req_op,
    input logic [DATA_W-1:0] base_val,
    input logic [OFF_W-1:0]  offset,
    input logic [WA_W-1:0]   mem_waddr,
    input logic [LANES-1:0]  mem_be,
    input logic              mem_we,
    input logic [DATA_W-1:0] ld_data,
    input logic              misalign
);
    logic [DATA_W-1:0] sum_chk;
    assign sum_chk = base_val + {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};

    // R1: word address follows the registered byte address
    a_r1_word_addr: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> mem_waddr == $past(sum_chk[DATA_W-1:LIDX_W]));

    // R5: a fault silences strobes, write and load data
    a_r5_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (mem_be == '0 && !mem_we && ld_data == '0));

    // R2 / R3 / R4: strobe population is 0, 1, 2 or all lanes
    a_r2_strobe_shape: assert property (@(posedge clk) disable iff (rst)
        ($countones(mem_be) == 0 || $countones(mem_be) == 1 ||
         $countones(mem_be) == 2 || mem_be == '1));

    // R4: aligned word requests strobe every lane
    a_r4_word_full: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_en) && $past(req_op[1:0]) == 2'b10 && !misalign)
        |-> mem_be == '1);

    // R10: idle cycles leave the outputs quiet
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req_en)) |-> (mem_be == '0 && !misalign && ld_data == '0));

    // R12: a write always carries at least one strobe
    a_r12_we_strobed: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_be != '0);
endmodule

bind ls_align_unit ls_align_chk #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .LANES(LANES), .LIDX_W(LIDX_W), .WA_W(WA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_en    (req_en),
    .req_op    (req_op),
    .base_val  (base_val),
    .offset    (offset),
    .mem_waddr (mem_waddr),
    .mem_be    (mem_be),
    .mem_we    (mem_we),
    .ld_data   (ld_data),
    .misalign  (misalign)
);

// File: tb/tb_ls_align_unit.sv
module tb_ls_align_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_en = 1'b0;
    logic [3:0]  req_op = '0;
    logic [31:0] base_val = '0;
    logic [15:0] offset = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_rdata = '0;
    logic [29:0] mem_waddr;
    logic [3:0]  mem_be;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] ld_data;
    logic        misalign;

    always #4 clk = ~clk;

    ls_align_unit dut (
        .clk(clk), .rst(rst), .req_en(req_en), .req_op(req_op),
        .base_val(base_val), .offset(offset), .st_data(st_data),
        .mem_rdata(mem_rdata), .mem_waddr(mem_waddr), .mem_be(mem_be),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .ld_data(ld_data),
        .misalign(misalign)
    );

    typedef struct {
        logic [29:0] waddr;
        logic [3:0]  be;
        logic        we;
        logic [31:0] wdata;
        logic [31:0] ld;
        logic        fault;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;
    bit   reported = 0;

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    // independent reference computed from the requirements
    function automatic exp_t model(logic en, logic [3:0] op, logic [31:0] b,
                                   logic [15:0] o, logic [31:0] sd,
                                   logic [31:0] rd, string tag);
        exp_t e;
        logic [31:0] a;
        int k, n, base_lane;
        logic ok;
        a = b + {{16{o[15]}}, o};
        k = int'(a[1:0]);
        e.waddr = a[31:2];
        e.be = 4'b0; e.we = 1'b0; e.wdata = 32'h0; e.ld = 32'h0; e.fault = 1'b0;
        e.tag = tag;
        n = (op[1:0] == 2'b00) ? 1 : (op[1:0] == 2'b01) ? 2 : 4;
        ok = (op[1:0] != 2'b11) && ((k % n) == 0);
        if (en) begin
            if (!ok) e.fault = 1'b1;
            else begin
                base_lane = k;
                for (int i = 0; i < n; i++) begin
                    e.be[base_lane+i] = 1'b1;
                    e.wdata[(base_lane+i)*8 +: 8] = sd[i*8 +: 8];
                end
                if (op[3]) e.we = 1'b1;
                else begin
                    for (int i = 0; i < n; i++) e.ld[i*8 +: 8] = rd[(base_lane+i)*8 +: 8];
                    if (!op[2] && n < 4 && e.ld[n*8-1])
                        for (int i = n; i < 4; i++) e.ld[i*8 +: 8] = 8'hFF;
                end
            end
        end
        return e;
    endfunction

    task automatic drive(logic en, logic [3:0] op, logic [31:0] b, logic [15:0] o,
                         logic [31:0] sd, logic [31:0] rd, string tag);
        @(negedge clk);
        req_en = en; req_op = op; base_val = b; offset = o;
        st_data = sd; mem_rdata = rd;
        @(posedge clk);
        q.push_back(model(en, op, b, o, sd, rd, tag));
    endtask

    // monitor: compare the registered outputs against the queued expectation
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            logic [31:0] m;
            e = q.pop_front();
            m = {{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}};
            n_vec++;
            if (mem_waddr !== e.waddr || mem_be !== e.be || mem_we !== e.we ||
                (mem_wdata & m) !== (e.wdata & m) || ld_data !== e.ld ||
                misalign !== e.fault) begin
                n_bad++;
                $display("FAIL %s: got waddr=%h be=%b we=%b wdata=%h ld=%h flt=%b exp waddr=%h be=%b we=%b wdata=%h ld=%h flt=%b",
                         e.tag, mem_waddr, mem_be, mem_we, mem_wdata & m, ld_data, misalign,
                         e.waddr, e.be, e.we, e.wdata & m, e.ld, e.fault);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R11: reset clears outputs even with a request pending
        req_en = 1; req_op = 4'b0010; base_val = 32'hFFFF_FFFC; mem_rdata = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (mem_waddr !== '0 || mem_be !== '0 || mem_we !== 0 || mem_wdata !== '0 ||
            ld_data !== '0 || misalign !== 0) begin
            n_bad++;
            $display("FAIL R11: got be=%b ld=%h waddr=%h exp all zero", mem_be, ld_data, mem_waddr);
        end
        rst = 0;

        // R1 / R9: aligned word loads, positive and negative offsets, next word
        drive(1, 4'b0010, 32'h0000_1000, 16'h0004, 0, 32'hCAFE_F00D, "R1_R9 word load");
        drive(1, 4'b0010, 32'h0000_2000, 16'hFFF8, 0, 32'h8000_0001, "R1 negative offset");
        drive(1, 4'b0010, 32'h0000_2000, 16'h0000, 0, 32'h1111_1111, "R1 word i");
        drive(1, 4'b0010, 32'h0000_2000, 16'h0004, 0, 32'h2222_2222, "R1 word i+4");
        drive(1, 4'b0010, 32'h7FFF_FFF0, 16'h8000, 0, 32'h0, "R1 big negative offset");

        // R2 / R7: byte loads on every lane, sign and zero fill
        for (int l = 0; l < 4; l++) begin
            drive(1, 4'b0000, 32'h0000_0100, 16'(l), 0, 32'h80F1_7F11, "R2_R7 byte signed");
            drive(1, 4'b0100, 32'h0000_0100, 16'(l), 0, 32'h80F1_7F11, "R2_R7 byte unsigned");
        end

        // R3 / R8: half-word loads on both halves
        drive(1, 4'b0001, 32'h0000_0200, 16'h0002, 0, 32'h80F1_1234, "R3_R8 half signed hi");
        drive(1, 4'b0101, 32'h0000_0200, 16'h0002, 0, 32'h80F1_1234, "R3_R8 half unsigned hi");
        drive(1, 4'b0001, 32'h0000_0200, 16'h0000, 0, 32'h0000_9ABC, "R3_R8 half signed lo");
        drive(1, 4'b0001, 32'h0000_0200, 16'h0000, 0, 32'hFFFF_7ABC, "R3_R8 half positive");

        // R6 / R12: stores
        for (int l = 0; l < 4; l++)
            drive(1, 4'b1000, 32'h0000_0300, 16'(l), 32'hA1B2_C3D4, 32'hFFFF_FFFF, "R6_R12 byte store");
        drive(1, 4'b1001, 32'h0000_0300, 16'h0002, 32'h5566_7788, 0, "R6_R3 half store hi");
        drive(1, 4'b1001, 32'h0000_0300, 16'h0000, 32'h5566_7788, 0, "R6_R3 half store lo");
        drive(1, 4'b1010, 32'h0000_0300, 16'h0000, 32'h0BAD_F00D, 32'h1234_5678, "R4_R12 word store");

        // R5: faults
        drive(1, 4'b0001, 32'h0000_0400, 16'h0001, 0, 32'hFFFF_FFFF, "R5 half odd load");
        drive(1, 4'b1001, 32'h0000_0400, 16'h0003, 32'hFFFF_FFFF, 0, "R5 half odd store");
        drive(1, 4'b1010, 32'h0000_0400, 16'h0002, 32'hFFFF_FFFF, 0, "R5 word store lane2");
        drive(1, 4'b0010, 32'h0000_0401, 16'h0000, 0, 32'hFFFF_FFFF, "R5 word load lane1");
        drive(1, 4'b0011, 32'h0000_0400, 16'h0000, 0, 32'hFFFF_FFFF, "R5 reserved size");

        // R10: idle requests have no effect at the outputs
        drive(0, 4'b1010, 32'h0000_0500, 16'h0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 idle store");
        drive(0, 4'b0001, 32'h0000_0501, 16'h0000, 0, 32'hFFFF_FFFF, "R10 idle misaligned");
        drive(1, 4'b0000, 32'h0000_0500, 16'h0000, 0, 32'h0000_00C3, "R7 after idle");

        @(negedge clk);
        req_en = 0;
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule